// File: doc/BRIEF.md
# Trace Configuration Register Guard

This block holds the configuration state of a trace packet generator and guards software access to it. It holds a control register with three fields: a run bit, a table-output mode bit and a transport-select bit. A status register holds a sticky output-error bit. Software reaches both registers through a single-cycle request port. Every request gets exactly one response on the following cycle. The response is either an acknowledge or a fault.

A request faults in three cases: the trace feature is reported as unsupported, the address is not one of the two registers, or the write would leave tracing running. A write that clears the run bit is allowed. When such a write or an output error stops tracing, the block emits a one-cycle flush pulse toward the cached output-table logic. The block drives the output route: the transport path when the transport-select bit is set, otherwise the table path when the table-output mode bit is set. The transport-select bit can only take effect when bit 3 of the capability word is 1.

The response is produced by a three-state machine. `S_IDLE` means no response is pending. `S_ACK` means an acknowledge is being returned. `S_FAULT` means a fault is being returned. From every state the machine moves on each cycle. A legal request leads to `S_ACK`. An illegal request leads to `S_FAULT`. A cycle with no request leads to `S_IDLE`.

Top module: `trc_cfg_guard`

## Requirements
- R1: After reset, the run, table-mode, transport-select and error bits are 0, and no response, route, activity or flush output is asserted.
- R2: When `feat_supported` is 0, every read or write faults, returns read data 0 and changes no register.
- R3: While the run bit is 1, any write that does not clear it faults and leaves every register unchanged. This covers a control write with bit 0 = 1 and any status write.
- R4: A control write that clears the run bit while tracing runs is acknowledged and loads all control fields from the write data.
- R5: Each request cycle is followed by exactly one cycle with `rsp_valid` = 1. `rsp_err` is 1 in that cycle for a faulting request, and the read data of a fault or of a write is 0.
- R6: Address 0 is control (bit 0 run, bit 1 table mode, bit 2 transport select) and address 1 is status (bit 0 error). Any other address faults.
- R7: The transport-select bit is stored only when `cap_word[3]` is 1. It reads as 0 and does not route while `cap_word[3]` is 0.
- R8: `route_fabric` is run AND transport select. `route_table` is run AND table mode AND NOT transport select, so transport select overrides table mode.
- R9: Each 1-to-0 change of the run bit, by a write or by an error, gives `flush_pulse` = 1 for exactly the one following cycle.
- R10: `out_err_evt` while running sets the sticky error bit and clears the run bit in the same cycle. While stopped it has no effect.
- R11: The error bit is cleared only by a legal status write with bit 0 = 0. A status write with bit 0 = 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_supported | input | 1 | Trace feature present; 0 makes every access fault |
| cap_word | input | 32 | Capability word; bit 3 permits transport select |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 32 | Write data |
| out_err_evt | input | 1 | Output error detected by the memory writer |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Fault response |
| rsp_rdata | output | 32 | Read data, 0 on fault or write |
| trace_active | output | 1 | Run bit |
| route_table | output | 1 | Output goes to the table-driven memory path |
| route_fabric | output | 1 | Output goes to the transport interface |
| flush_pulse | output | 1 | One-cycle flush of cached table entries |

## Verification
A request sampled at clock edge E changes the registers at E. The response, the route outputs, `trace_active` and any flush pulse therefore all belong to the cycle that follows E. The bench drives inputs on the falling edge and samples every result one time step after E. `rsp_valid` is checked again one cycle later to confirm it has returned to 0. An error event is handled the same way: its effect on the run bit and the flush pulse is read one step after the edge that sampled it, and the sticky bit is then read back through a status read.

// File: rtl/trc_cfg_pkg.sv
package trc_cfg_pkg;
    localparam int unsigned REG_CTRL = 0;
    localparam int unsigned REG_STAT = 1;
    localparam int unsigned CTL_RUN  = 0;
    localparam int unsigned CTL_TBL  = 1;
    localparam int unsigned CTL_FAB  = 2;
    localparam int unsigned CTL_W    = 3;
    localparam int unsigned STS_ERR  = 0;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ACK   = 2'd1,
        S_FAULT = 2'd2
    } acc_state_e;

    typedef struct packed {
        logic fab;
        logic tbl;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/trc_cfg_fsm.sv
module trc_cfg_fsm
    import trc_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feat_supported,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wdata_run,
    input  logic              run_q,
    input  logic [DATA_W-1:0] rd_value,
    output logic              wr_commit,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    acc_state_e        state_q, state_d;
    logic [DATA_W-1:0] rdata_q;
    logic              addr_known;
    logic              wr_locked;
    logic              legal;

    assign addr_known = (req_addr == ADDR_W'(REG_CTRL)) || (req_addr == ADDR_W'(REG_STAT));
    // A write is locked when tracing would still run after it.
    assign wr_locked  = req_write && run_q &&
                        !((req_addr == ADDR_W'(REG_CTRL)) && !wdata_run);
    assign legal      = feat_supported && addr_known && !wr_locked;
    assign wr_commit  = req_valid && req_write && legal;

    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE, S_ACK, S_FAULT: begin
                if (req_valid) state_d = legal ? S_ACK : S_FAULT;
                else           state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (req_valid && legal && !req_write) ? rd_value : '0;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_ACK:   rsp_valid = 1'b1;
            S_FAULT: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default: ;
        endcase
    end
    assign rsp_rdata = rdata_q;

    // R5
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R5
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2
    unsup_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !feat_supported) |=> (rsp_err && rsp_rdata == '0));
endmodule

// File: rtl/trc_cfg_regs.sv
module trc_cfg_regs
    import trc_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              cap_fab,
    input  logic              out_err_evt,
    output ctrl_t             ctrl,
    output logic              err_q,
    output logic [DATA_W-1:0] rd_value
);
    ctrl_t ctrl_q;
    logic  sel_ctrl, sel_stat;

    assign sel_ctrl = (req_addr == ADDR_W'(REG_CTRL));
    assign sel_stat = (req_addr == ADDR_W'(REG_STAT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_commit && sel_ctrl) begin
                ctrl_q.run <= wdata[CTL_RUN];
                ctrl_q.tbl <= wdata[CTL_TBL];
                ctrl_q.fab <= wdata[CTL_FAB] & cap_fab;
            end
            if (wr_commit && sel_stat && !wdata[STS_ERR]) err_q <= 1'b0;
            if (ctrl_q.run && out_err_evt) begin
                err_q      <= 1'b1;
                ctrl_q.run <= 1'b0;
            end
        end
    end

    always_comb begin
        ctrl     = ctrl_q;
        ctrl.fab = ctrl_q.fab & cap_fab;
    end

    always_comb begin
        rd_value = '0;
        if (sel_ctrl) begin
            rd_value[CTL_RUN] = ctrl.run;
            rd_value[CTL_TBL] = ctrl.tbl;
            rd_value[CTL_FAB] = ctrl.fab;
        end else if (sel_stat) begin
            rd_value[STS_ERR] = err_q;
        end
    end

    // R10
    err_stops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.run && out_err_evt) |=> (!ctrl_q.run && err_q));
    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !wr_commit) |=> err_q);
endmodule

// File: rtl/trc_cfg_route.sv
module trc_cfg_route
    import trc_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    output logic  trace_active,
    output logic  route_table,
    output logic  route_fabric,
    output logic  flush_pulse
);
    logic run_d1;

    always_ff @(posedge clk) begin
        if (!rst_n) run_d1 <= 1'b0;
        else        run_d1 <= ctrl.run;
    end

    assign trace_active = ctrl.run;
    assign route_fabric = ctrl.run & ctrl.fab;
    assign route_table  = ctrl.run & ctrl.tbl & ~ctrl.fab;
    assign flush_pulse  = run_d1 & ~ctrl.run;

    // R8
    route_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(route_fabric && route_table));
    // R9
    flush_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |=> !flush_pulse);
    // R9
    flush_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> !trace_active);
endmodule

// File: rtl/trc_cfg_guard.sv
module trc_cfg_guard
    import trc_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CAP_W   = 32,
    parameter int unsigned CAP_FAB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feat_supported,
    input  logic [CAP_W-1:0]  cap_word,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              out_err_evt,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              trace_active,
    output logic              route_table,
    output logic              route_fabric,
    output logic              flush_pulse
);
    ctrl_t             ctrl;
    logic              err_q;
    logic              wr_commit;
    logic [DATA_W-1:0] rd_value;
    logic              unused_bits;

    assign unused_bits = ^{cap_word, req_wdata};

    trc_cfg_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .feat_supported(feat_supported),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .wdata_run     (req_wdata[CTL_RUN]),
        .run_q         (ctrl.run),
        .rd_value      (rd_value),
        .wr_commit     (wr_commit),
        .rsp_valid     (rsp_valid),
        .rsp_err       (rsp_err),
        .rsp_rdata     (rsp_rdata)
    );

    trc_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_commit  (wr_commit),
        .req_addr   (req_addr),
        .wdata      (req_wdata[CTL_W-1:0]),
        .cap_fab    (cap_word[CAP_FAB]),
        .out_err_evt(out_err_evt),
        .ctrl       (ctrl),
        .err_q      (err_q),
        .rd_value   (rd_value)
    );

    trc_cfg_route u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl        (ctrl),
        .trace_active(trace_active),
        .route_table (route_table),
        .route_fabric(route_fabric),
        .flush_pulse (flush_pulse)
    );

    // R3
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && trace_active && req_wdata[CTL_RUN] && !out_err_evt)
        |=> (rsp_err && $stable(ctrl) && $stable(err_q)));
    // R7
    fab_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_word[CAP_FAB] |-> !route_fabric);
endmodule

// File: tb/trc_cfg_guard_bench.sv
module trc_cfg_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feat_supported = 1'b1;
    logic [31:0] cap_word = 32'h8;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        out_err_evt = 1'b0;
    logic        rsp_valid, rsp_err, trace_active, route_table, route_fabric, flush_pulse;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    trc_cfg_guard u_trc_cfg_guard (
        .clk(clk), .rst_n(rst_n), .feat_supported(feat_supported), .cap_word(cap_word),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .out_err_evt(out_err_evt), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .trace_active(trace_active),
        .route_table(route_table), .route_fabric(route_fabric), .flush_pulse(flush_pulse)
    );

    typedef struct packed {
        logic       wr;
        logic [3:0] addr;
        logic [7:0] wdata;
        logic       sup;
        logic       capb;
        logic       xerr;
        logic [7:0] xrd;
        logic       xfl;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0}, // R6 read control after reset
        '{1'b0, 4'd1, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0}, // R6 read status after reset
        '{1'b1, 4'd0, 8'h03, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0}, // R4 start with table mode
        '{1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h03, 1'b0}, // R6 control readback
        '{1'b1, 4'd0, 8'h07, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0}, // R3 write keeping run set
        '{1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h03, 1'b0}, // R3 unchanged
        '{1'b1, 4'd1, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0}, // R3 status write while running
        '{1'b1, 4'd0, 8'h04, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1}, // R4 R9 clear run, set transport
        '{1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h04, 1'b0}, // R4 all fields loaded
        '{1'b0, 4'd5, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0}, // R6 unknown address
        '{1'b0, 4'd0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0}, // R2 read unsupported
        '{1'b1, 4'd0, 8'h05, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0}, // R2 write unsupported
        '{1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h04, 1'b0}, // R2 nothing changed
        '{1'b1, 4'd0, 8'h05, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R7 transport without capability
        '{1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h01, 1'b0}, // R7 transport not stored
        '{1'b1, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1}, // R9 stop by write
        '{1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0}  // R6 back to idle
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xact(input logic w, input logic [3:0] a, input logic [7:0] d,
                        input logic sup, input logic capb,
                        output logic v, output logic e, output logic [31:0] rd,
                        output logic fl);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = {24'h0, d};
        feat_supported = sup; cap_word = capb ? 32'h8 : 32'h0;
        @(posedge clk);
        #1;
        v = rsp_valid; e = rsp_err; rd = rsp_rdata; fl = flush_pulse;
        req_valid = 1'b0; req_write = 1'b0; feat_supported = 1'b1; cap_word = 32'h8;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R5 watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic v, e, fl;
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check("R1 trace_active", {31'h0, trace_active}, 32'h0);
        check("R1 routes", {30'h0, route_table, route_fabric}, 32'h0);
        check("R1 flush", {31'h0, flush_pulse}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            xact(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].sup, VECS[i].capb, v, e, rd, fl);
            check($sformatf("R5 vec%0d valid", i), {31'h0, v}, 32'h1);
            check($sformatf("R5 vec%0d err", i), {31'h0, e}, {31'h0, VECS[i].xerr});
            check($sformatf("R6 vec%0d rdata", i), rd, {24'h0, VECS[i].xrd});
            check($sformatf("R9 vec%0d flush", i), {31'h0, fl}, {31'h0, VECS[i].xfl});
        end

        // R5 no response without a request
        @(posedge clk); #1;
        check("R5 idle valid", {31'h0, rsp_valid}, 32'h0);

        // R8 table route
        xact(1'b1, 4'd0, 8'h03, 1'b1, 1'b1, v, e, rd, fl);
        check("R8 table route", {29'h0, trace_active, route_table, route_fabric}, 32'h6);
        xact(1'b1, 4'd0, 8'h00, 1'b1, 1'b1, v, e, rd, fl);
        // R8 transport overrides table
        xact(1'b1, 4'd0, 8'h07, 1'b1, 1'b1, v, e, rd, fl);
        check("R8 transport override", {30'h0, route_table, route_fabric}, 32'h1);
        // R7 capability withdrawn stops transport routing
        @(negedge clk); cap_word = 32'h0; #1;
        check("R7 no route without capability", {31'h0, route_fabric}, 32'h0);
        @(negedge clk); cap_word = 32'h8;

        // R10 output error while running
        out_err_evt = 1'b1;
        @(posedge clk); #1;
        out_err_evt = 1'b0;
        check("R10 run cleared", {31'h0, trace_active}, 32'h0);
        check("R9 flush on error", {31'h0, flush_pulse}, 32'h1);
        @(posedge clk); #1;
        check("R9 flush one cycle", {31'h0, flush_pulse}, 32'h0);
        xact(1'b0, 4'd1, 8'h00, 1'b1, 1'b1, v, e, rd, fl);
        check("R10 error sticky set", rd, 32'h1);
        xact(1'b0, 4'd0, 8'h00, 1'b1, 1'b1, v, e, rd, fl);
        check("R10 other fields kept", rd, 32'h6);

        // R11 clear rules
        xact(1'b1, 4'd1, 8'h01, 1'b1, 1'b1, v, e, rd, fl);
        check("R11 write one ok", {31'h0, e}, 32'h0);
        xact(1'b0, 4'd1, 8'h00, 1'b1, 1'b1, v, e, rd, fl);
        check("R11 write one keeps error", rd, 32'h1);
        xact(1'b1, 4'd1, 8'h00, 1'b1, 1'b1, v, e, rd, fl);
        xact(1'b0, 4'd1, 8'h00, 1'b1, 1'b1, v, e, rd, fl);
        check("R11 write zero clears", rd, 32'h0);

        // R10 error event ignored while stopped
        @(negedge clk); out_err_evt = 1'b1;
        @(negedge clk); out_err_evt = 1'b0;
        xact(1'b0, 4'd1, 8'h00, 1'b1, 1'b1, v, e, rd, fl);
        check("R10 ignored while stopped", rd, 32'h0);

        // R1 reset mid-run clears control
        xact(1'b1, 4'd0, 8'h07, 1'b1, 1'b1, v, e, rd, fl);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 reset clears run", {29'h0, trace_active, route_table, route_fabric}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        xact(1'b0, 4'd0, 8'h00, 1'b1, 1'b1, v, e, rd, fl);
        check("R1 control zero after reset", rd, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule